// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block is the host side of a link to a 12-bit, two-input sampling converter that has a serial port and a separate convert strobe. A one-cycle start request causes the block to raise the convert strobe. The strobe stays high for a conversion time set by a parameter in system clock cycles. The block then lowers the strobe and runs a full-duplex serial transfer of exactly twelve serial clocks. During that transfer it sends a two-bit input-select word and collects the twelve result bits. The result appears on a parallel output together with a one-cycle valid pulse.

The converter applies the select word from a transfer to the conversion that comes after it. For this reason the block keeps track of which selection was in force for each conversion and tags every result with it. A sleep-hold input keeps the strobe high once the conversion time is over, which leaves the converter in its low-power state. The transfer starts only after the hold is released. The serial clock rate is set by a divider parameter.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With the block idle, a start request sampled high on a clock edge drives the convert strobe and busy high from that edge on.
- R2: With sleep hold low, the convert strobe stays high for exactly CONV_CYCLES system clock cycles.
- R3: If sleep hold is high when the conversion time ends, the strobe stays high, with no serial clock, until sleep hold is sampled low. The strobe falls on that edge.
- R4: The serial clock idles low. It rises SCLK_HALF cycles after the strobe falls. Each transfer has exactly 12 pulses, each high for SCLK_HALF cycles and low for SCLK_HALF cycles.
- R5: The serial data output carries the single-ended select bit (1 = single-ended) from the strobe's fall until the first falling serial edge. It then carries the odd/sign bit until the second falling edge, and 0 after that.
- R6: The serial data input is sampled on each rising serial edge, and the first bit sampled is the most significant result bit.
- R7: The valid output goes high for one cycle, starting at the edge of the twelfth falling serial edge (24·SCLK_HALF cycles after the strobe falls). Busy drops on that same edge.
- R8: Each result's tag outputs carry the select bits sent in the previous transfer. The first result after reset carries single-ended = 1, odd/sign = 0.
- R9: A start request while busy is ignored: there is no second strobe rise, and the select word that is sent stays the one captured at acceptance.
- R10: During and right after reset, strobe, serial clock, serial data output, busy and valid are all 0.
- R11: The result code is passed through as plain straight binary over its full range, 0 to 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a conversion (accepted when idle) |
| sel_single_i | input | 1 | Select bit: 1 = single-ended, 0 = differential |
| sel_odd_i | input | 1 | Select bit: odd channel / polarity |
| sleep_hold_i | input | 1 | Keep strobe high after the conversion time |
| busy_o | output | 1 | Sequence in progress |
| conv_o | output | 1 | Convert strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdi_o | output | 1 | Serial data to the converter |
| sdo_i | input | 1 | Serial data from the converter |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_code_o | output | 12 | Conversion result, straight binary |
| res_single_o | output | 1 | Tag: single-ended bit in force for this result |
| res_odd_o | output | 1 | Tag: odd/sign bit in force for this result |

## Verification
Counting from the edge that samples the start request, the strobe is high at the next sample point. It stays high for CONV_CYCLES cycles, or longer while sleep hold is asserted. The first serial rise comes SCLK_HALF cycles after the strobe falls, and the valid pulse comes 24·SCLK_HALF cycles after the strobe falls. The bench samples on the falling system clock edge and counts those sample points between events, so each interval is compared with its exact expected count and not with a window. A behavioural converter model in the bench captures the select bits on rising serial edges and shifts out a code chosen by each test. The model also tracks the selection in force, which gives the expected tag.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int RES_W = 12;

    typedef struct packed {
        logic single;
        logic odd;
    } mux_sel_t;

    localparam mux_sel_t SEL_AT_RESET = '{single: 1'b1, odd: 1'b0};

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_XFER
    } seq_state_t;

    function automatic logic [RES_W-1:0] tx_frame(input mux_sel_t s);
        return {s.single, s.odd, {(RES_W-2){1'b0}}};
    endfunction

endpackage

// File: rtl/adcseq_sclk_gen.sv
module adcseq_sclk_gen #(
    parameter int SCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int HW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [HW-1:0] HLAST = HW'(SCLK_HALF - 1);

    logic [HW-1:0] hcnt;
    logic          wrap;

    assign wrap     = run && (hcnt == HLAST);
    assign rise_stb = wrap && !sclk;
    assign fall_stb = wrap && sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            hcnt <= '0;
            sclk <= ~sclk;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end
endmodule

// File: rtl/adcseq_shifter.sv
module adcseq_shifter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift_tx,
    input  logic         sample_rx,
    input  logic         ser_in,
    output logic         ser_out,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] tx_q;

    assign ser_out = tx_q[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q    <= '0;
            rx_word <= '0;
        end else if (load) begin
            tx_q    <= load_word;
            rx_word <= '0;
        end else begin
            if (shift_tx)
                tx_q <= {tx_q[W-2:0], 1'b0};
            if (sample_rx)
                rx_word <= {rx_word[W-2:0], ser_in};
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adcseq_pkg::*;
#(
    parameter int CONV_CYCLES = 40,
    parameter int SCLK_HALF   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             sel_single_i,
    input  logic             sel_odd_i,
    input  logic             sleep_hold_i,
    output logic             busy_o,
    output logic             conv_o,
    output logic             sclk_o,
    output logic             sdi_o,
    input  logic             sdo_i,
    output logic             res_valid_o,
    output logic [RES_W-1:0] res_code_o,
    output logic             res_single_o,
    output logic             res_odd_o
);
    localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] CLAST = CW'(CONV_CYCLES - 1);
    localparam int BW = $clog2(RES_W);
    localparam logic [BW-1:0] BLAST = BW'(RES_W - 1);

    seq_state_t       state;
    logic [CW-1:0]    ccnt;
    logic [BW-1:0]    bcnt;
    mux_sel_t         sent_sel;
    mux_sel_t         live_sel;
    mux_sel_t         res_sel;
    logic             accept;
    logic             rise_stb;
    logic             fall_stb;
    logic [RES_W-1:0] rx_word;
    mux_sel_t         req_sel;

    assign req_sel = '{single: sel_single_i, odd: sel_odd_i};
    assign accept  = (state == ST_IDLE) && start_i;
    assign busy_o  = (state != ST_IDLE);
    assign res_single_o = res_sel.single;
    assign res_odd_o    = res_sel.odd;

    adcseq_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_sclk (
        .clk      (clk),
        .rst      (rst),
        .run      (state == ST_XFER),
        .sclk     (sclk_o),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    adcseq_shifter #(.W(RES_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_word (tx_frame(req_sel)),
        .shift_tx  (fall_stb),
        .sample_rx (rise_stb),
        .ser_in    (sdo_i),
        .ser_out   (sdi_o),
        .rx_word   (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            conv_o      <= 1'b0;
            ccnt        <= '0;
            bcnt        <= '0;
            sent_sel    <= SEL_AT_RESET;
            live_sel    <= SEL_AT_RESET;
            res_sel     <= SEL_AT_RESET;
            res_code_o  <= '0;
            res_valid_o <= 1'b0;
        end else begin
            res_valid_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state    <= ST_CONV;
                        conv_o   <= 1'b1;
                        ccnt     <= '0;
                        sent_sel <= req_sel;
                    end
                end
                ST_CONV: begin
                    if (ccnt != CLAST) begin
                        ccnt <= ccnt + 1'b1;
                    end else if (!sleep_hold_i) begin
                        conv_o <= 1'b0;
                        state  <= ST_XFER;
                        bcnt   <= '0;
                    end
                end
                ST_XFER: begin
                    if (fall_stb) begin
                        if (bcnt == BLAST) begin
                            state       <= ST_IDLE;
                            bcnt        <= '0;
                            res_valid_o <= 1'b1;
                            res_code_o  <= rx_word;
                            res_sel     <= live_sel;
                            live_sel    <= sent_sel;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int CONV_CYCLES = 40,
    parameter int SCLK_HALF   = 4
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic busy_o,
    input logic conv_o,
    input logic sclk_o,
    input logic res_valid_o
);
    int unsigned hi_run;

    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= 0;
        else if (conv_o)
            hi_run <= hi_run + 1;
        else
            hi_run <= 0;
    end

    p_conv_start_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_o) |-> ($past(start_i) && !$past(busy_o)))
        else $error("conv strobe rose without an accepted start");

    p_conv_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_o) |-> (hi_run >= CONV_CYCLES))
        else $error("conv strobe shorter than conversion time");

    p_sclk_gated_r4: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> (!conv_o && busy_o))
        else $error("serial clock outside transfer");

    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |=> !res_valid_o)
        else $error("valid longer than one cycle");

    p_valid_idle_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> (!busy_o && !sclk_o && !conv_o))
        else $error("valid while sequence still running");
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .CONV_CYCLES(CONV_CYCLES),
    .SCLK_HALF  (SCLK_HALF)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .conv_o      (conv_o),
    .sclk_o      (sclk_o),
    .res_valid_o (res_valid_o)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    localparam int C = 8;
    localparam int H = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        sel_single_i = 1'b0;
    logic        sel_odd_i = 1'b0;
    logic        sleep_hold_i = 1'b0;
    logic        busy_o, conv_o, sclk_o, sdi_o, sdo_i;
    logic        res_valid_o, res_single_o, res_odd_o;
    logic [11:0] res_code_o;

    int n_run = 0;
    int n_bad = 0;
    int cyc = 0;

    // converter model state
    logic [11:0] adc_code = 12'h000;
    int          bidx = 12;
    int          rcnt = 0;
    logic        rx_single = 1'b0;
    logic        rx_odd = 1'b0;
    logic [1:0]  pend = 2'b10;
    logic [1:0]  cur_tag = 2'b10;
    int          conv_rises = 0;
    int          sclk_rises = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_seq_ctrl #(.CONV_CYCLES(C), .SCLK_HALF(H)) uut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .sel_single_i(sel_single_i), .sel_odd_i(sel_odd_i),
        .sleep_hold_i(sleep_hold_i), .busy_o(busy_o), .conv_o(conv_o),
        .sclk_o(sclk_o), .sdi_o(sdi_o), .sdo_i(sdo_i),
        .res_valid_o(res_valid_o), .res_code_o(res_code_o),
        .res_single_o(res_single_o), .res_odd_o(res_odd_o)
    );

    assign sdo_i = (bidx >= 0 && bidx < 12) ? adc_code[bidx] : 1'b0;

    always @(posedge conv_o or negedge sclk_o) begin
        if (conv_o) bidx = 11;
        else        bidx = bidx - 1;
    end

    always @(posedge conv_o) begin
        cur_tag    = pend;
        conv_rises = conv_rises + 1;
        rcnt       = 0;
    end

    always @(posedge sclk_o) begin
        sclk_rises = sclk_rises + 1;
        if (rcnt == 0) rx_single = sdi_o;
        if (rcnt == 1) begin
            rx_odd = sdi_o;
            pend   = {rx_single, sdi_o};
        end
        rcnt = rcnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk({conv_o, sclk_o, sdi_o, busy_o, res_valid_o} == 5'b0, "R10 in reset",
            {conv_o, sclk_o, sdi_o, busy_o, res_valid_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({conv_o, sclk_o, sdi_o, busy_o, res_valid_o} == 5'b0, "R10 after reset",
            {conv_o, sclk_o, sdi_o, busy_o, res_valid_o}, 0);
    endtask

    // one full conversion; hold>0 keeps sleep hold for that many extra cycles;
    // poke pulses a start request during the transfer
    task automatic t_conv(input logic s, input logic o, input logic [11:0] code,
                          input int hold, input bit poke, input string name);
        int hi;
        int lo;
        int t_fall;
        logic [1:0] exp_tag;
        adc_code     = code;
        conv_rises   = 0;
        sclk_rises   = 0;
        @(negedge clk);
        start_i      = 1'b1;
        sel_single_i = s;
        sel_odd_i    = o;
        sleep_hold_i = (hold > 0);
        @(negedge clk);
        start_i      = 1'b0;
        chk(conv_o && busy_o, {"R1 start ", name}, {conv_o, busy_o}, 3);
        hi = 0;
        while (conv_o) begin
            hi++;
            if (hold > 0 && hi == C + hold) sleep_hold_i = 1'b0;
            if (hold > 0 && hi == C + 1)
                chk(!sclk_o, {"R3 no sclk in sleep ", name}, sclk_o, 0);
            @(negedge clk);
        end
        chk(hi == C + hold, {(hold > 0) ? "R3 strobe len " : "R2 strobe len ", name}, hi, C + hold);
        exp_tag = cur_tag;
        t_fall = cyc;
        chk(sdi_o == s, {"R5 first bit ", name}, sdi_o, s);
        lo = 0;
        while (!sclk_o) begin
            lo++;
            @(negedge clk);
        end
        chk(lo == H, {"R4 first rise delay ", name}, lo, H);
        hi = 0;
        while (sclk_o) begin
            hi++;
            @(negedge clk);
        end
        chk(hi == H, {"R4 high width ", name}, hi, H);
        chk(sdi_o == o, {"R5 second bit ", name}, sdi_o, o);
        while (sclk_o == 1'b0 && busy_o) @(negedge clk);
        while (sclk_o) @(negedge clk);
        chk(sdi_o == 1'b0, {"R5 trailing zero ", name}, sdi_o, 0);
        if (poke) begin
            start_i      = 1'b1;
            sel_single_i = ~s;
            sel_odd_i    = ~o;
            @(negedge clk);
            start_i      = 1'b0;
        end
        while (!res_valid_o) @(negedge clk);
        chk(cyc - t_fall == 24 * H, {"R7 valid timing ", name}, cyc - t_fall, 24 * H);
        chk(!busy_o, {"R7 busy drops ", name}, busy_o, 0);
        chk(res_code_o == code, {"R6 R11 code ", name}, res_code_o, code);
        chk({res_single_o, res_odd_o} == exp_tag, {"R8 tag ", name},
            {res_single_o, res_odd_o}, exp_tag);
        chk(sclk_rises == 12, {"R4 pulse count ", name}, sclk_rises, 12);
        chk({rx_single, rx_odd} == {s, o}, {"R9 R5 sent select ", name},
            {rx_single, rx_odd}, {s, o});
        chk(conv_rises == 1, {"R9 single strobe ", name}, conv_rises, 1);
        @(negedge clk);
        chk(!res_valid_o, {"R7 one-cycle valid ", name}, res_valid_o, 0);
        chk(!sclk_o && !conv_o, {"R4 idle low ", name}, {sclk_o, conv_o}, 0);
    endtask

    task automatic t_first_tag();
        t_conv(1'b0, 1'b1, 12'hA5C, 0, 1'b0, "first");
        chk({res_single_o, res_odd_o} == 2'b10, "R8 reset tag", {res_single_o, res_odd_o}, 2);
    endtask

    task automatic t_next_tag();
        t_conv(1'b1, 1'b1, 12'h3C9, 0, 1'b0, "second");
        chk({res_single_o, res_odd_o} == 2'b01, "R8 previous select", {res_single_o, res_odd_o}, 1);
    endtask

    initial begin : watchdog
        #500000;
        n_run++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_first_tag();
        t_next_tag();
        t_conv(1'b0, 1'b0, 12'h000, 0, 1'b0, "zero");
        t_conv(1'b1, 1'b0, 12'hFFF, 0, 1'b0, "full");
        t_conv(1'b0, 1'b1, 12'h801, 0, 1'b1, "busy_poke");
        t_conv(1'b1, 1'b1, 12'h17E, 10, 1'b0, "sleep");
        t_conv(1'b0, 1'b0, 12'h555, 1, 1'b0, "sleep_short");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule